// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block sequences the shutdown and restart of a synthesized output clock. An asynchronous, active-high power-down request is brought into the reference-clock domain. The block then closes a glitch-free gate on the synthesized clock and waits until the gate confirms it is closed. Only then does it release the output drivers to high impedance and power down the PLL and the oscillator.

When the request is withdrawn, the block powers the PLL and oscillator back up and drives the outputs again, with the pair parked at a fixed level. It then counts a programmable number of reference cycles as the PLL settling time before it reopens the gate. If power-down is requested again while the block is waiting, it returns straight to the powered-down state.

The surrounding chip feeds the block the reference clock, the raw power-down pin and the PLL output. It takes the differential pair, the driver enable and the two power-down controls back to the analog blocks.

Top module: `clkstop_seq`

## Requirements
- R1: While reset is held and after it is released with power-down low, out_oe is 1, pll_pd and osc_pd are 0, and the pair rests at clk_p=0, clk_n=1. The first clk_p rising edge comes no sooner than STAB_CYCLES reference cycles after reset release.
- R2: pd_async passes through a SYNC_STAGES-flop synchronizer on ref_clk. No output reacts to a change of pd_async at the first ref_clk rising edge after the change.
- R3: Every high pulse on clk_p lasts exactly one high phase of synth_clk. Every low interval is at least one low phase of synth_clk, including around a stop and a restart.
- R4: In the powered-down state, out_oe is 0 (drivers released), pll_pd is 1 and osc_pd is 1 (1 means powered down).
- R5: out_oe falls and pll_pd/osc_pd rise only after the gate has been confirmed closed through the return synchronizer. When out_oe falls, the last clk_p rising edge lies at least one reference period in the past.
- R6: After power-down is released, pll_pd and osc_pd fall and out_oe rises together on one ref_clk edge. clk_p stays low for STAB_CYCLES reference cycles from that edge and makes its first rising edge within the following two reference cycles.
- R7: A power-down request that arrives during the settling wait returns the block to the powered-down state (R4) within four reference cycles, with no clk_p pulse.
- R8: clk_n is always the complement of clk_p. While gated, clk_p=0 and clk_n=1.
- R9: A power-down pulse captured for a single reference cycle still produces a complete stop: out_oe falls exactly once, and the clock then restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, must run during power-down |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pd_async | input | 1 | Asynchronous active-high power-down request |
| synth_clk | input | 1 | Synthesized clock from the PLL |
| clk_p | output | 1 | Gated clock, true side |
| clk_n | output | 1 | Gated clock, complement side |
| out_oe | output | 1 | Output driver enable, 0 = high impedance |
| pll_pd | output | 1 | PLL power-down, 1 = off |
| osc_pd | output | 1 | Oscillator power-down, 1 = off |

## Verification
A sequencer stuck in the stopping state shows at the ports as out_oe never falling after a request, which is visible a few reference cycles later. A counter that ends early or late moves the first restarted clk_p edge outside its two-cycle window, so the error shows one settling interval after release. A gate that closes in the wrong phase produces a short high pulse on clk_p in the same synthesized cycle. The bench measures every pulse width to catch it. A missed abort during the wait leaves out_oe high beyond four cycles.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_OFF  = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_t;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic synth_clk,
  input  logic rst_n,
  input  logic gate_req,
  output logic gate_open,
  output logic clk_p,
  output logic clk_n
);

  logic req_syn;
  logic en_lat;

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk   (synth_clk),
    .rst_n (rst_n),
    .d     (gate_req),
    .q     (req_syn)
  );

  // Transparent only in the low phase: a started high phase always finishes.
  always_latch begin
    if (!rst_n)          en_lat = 1'b0;
    else if (!synth_clk) en_lat = req_syn;
  end

  assign gate_open = en_lat;
  assign clk_p     = synth_clk & en_lat;
  assign clk_n     = ~clk_p;

endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
  import clkstop_pkg::*;
#(
  parameter int STAB_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_s,
  input  logic ack_s,
  output logic gate_req,
  output logic out_oe,
  output logic pwr_down
);

  localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             stab_done;

  assign stab_done = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (pd_s && ack_s) state_d = ST_STOP;
      ST_STOP: if (!ack_s)        state_d = ST_OFF;
      ST_OFF:  if (!pd_s)         state_d = ST_WAIT;
      ST_WAIT: begin
        if (pd_s)           state_d = ST_OFF;
        else if (stab_done) state_d = ST_RUN;
      end
      default:              state_d = ST_OFF;
    endcase
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (state_q != ST_WAIT) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!stab_done) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign gate_req = (state_q == ST_RUN);
  assign out_oe   = (state_q != ST_OFF);
  assign pwr_down = (state_q == ST_OFF);

  // R2: a synchronized request with the gate open always starts the stop
  p_run_to_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && pd_s && ack_s) |=> (state_q == ST_STOP));

  // R5: stopping holds until the closed gate is confirmed
  p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && ack_s) |=> (state_q == ST_STOP));

  // R5: powered-down state is only entered from stopping or from the wait
  p_off_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && $past(state_q) != ST_OFF) |->
      ($past(state_q) == ST_STOP || $past(state_q) == ST_WAIT));

  // R6: the gate reopens only after the full settling count
  p_wait_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_WAIT) |-> ($past(cnt_q) == CNT_LAST));

  // R7: a new request during the wait aborts it on the next edge
  p_wait_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && pd_s) |=> (state_q == ST_OFF));

  // R9: release from powered-down always goes through the wait
  p_off_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !pd_s) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CYCLES = 256
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pd_async,
  input  logic synth_clk,
  output logic clk_p,
  output logic clk_n,
  output logic out_oe,
  output logic pll_pd,
  output logic osc_pd
);

  logic rst_ref_n;
  logic rst_syn_n;
  logic pd_s;
  logic ack_s;
  logic gate_req;
  logic gate_open;
  logic pwr_down;

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_ref (
    .clk (ref_clk), .rst_n (rst_n), .d (1'b1), .q (rst_ref_n)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_syn (
    .clk (synth_clk), .rst_n (rst_n), .d (1'b1), .q (rst_syn_n)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
    .clk (ref_clk), .rst_n (rst_ref_n), .d (pd_async), .q (pd_s)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk (ref_clk), .rst_n (rst_ref_n), .d (gate_open), .q (ack_s)
  );

  clkstop_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_fsm (
    .clk      (ref_clk),
    .rst_n    (rst_ref_n),
    .pd_s     (pd_s),
    .ack_s    (ack_s),
    .gate_req (gate_req),
    .out_oe   (out_oe),
    .pwr_down (pwr_down)
  );

  clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .synth_clk (synth_clk),
    .rst_n     (rst_syn_n),
    .gate_req  (gate_req),
    .gate_open (gate_open),
    .clk_p     (clk_p),
    .clk_n     (clk_n)
  );

  assign pll_pd = pwr_down;
  assign osc_pd = pwr_down;

endmodule

// File: tb/clkstop_seq_bench.sv
`timescale 1ns/1ns
module clkstop_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYNTH_HALF = 2;
  localparam int STAB       = 16;

  logic ref_clk, rst_n, pd_async, synth_clk;
  logic clk_p, clk_n, out_oe, pll_pd, osc_pd;

  int n_chk, n_fail;
  int rises, runts, diff_err, oe_falls;
  bit started;
  time last_rise_t, last_fall_t;

  clkstop_seq #(.SYNC_STAGES(2), .STAB_CYCLES(STAB)) u_clkstop_seq (
    .ref_clk (ref_clk), .rst_n (rst_n), .pd_async (pd_async),
    .synth_clk (synth_clk), .clk_p (clk_p), .clk_n (clk_n),
    .out_oe (out_oe), .pll_pd (pll_pd), .osc_pd (osc_pd)
  );

  initial begin
    ref_clk = 1'b0;
    forever #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  end

  initial begin
    synth_clk = 1'b0;
    #1;
    forever #(SYNTH_HALF) synth_clk = ~synth_clk;
  end

  always @(posedge clk_p) if (started) begin
    if (rises > 0 && ($time - last_fall_t) < SYNTH_HALF) runts++;
    last_rise_t = $time;
    rises++;
  end

  always @(negedge clk_p) if (started && rises > 0) begin
    if (($time - last_rise_t) != SYNTH_HALF) runts++;
    last_fall_t = $time;
  end

  always @(negedge out_oe) if (started) oe_falls++;

  always begin
    #2;
    if (started && (clk_n !== ~clk_p)) diff_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge ref_clk);
    #3;
  endtask

  task automatic wait_running();
    for (int i = 0; i < STAB + 40; i++) begin
      int r;
      r = rises;
      step();
      if (rises > r) break;
    end
  endtask

  task automatic wait_oe(input bit lvl, output int n);
    n = 0;
    while (out_oe !== lvl && n < 30) begin
      step();
      n++;
    end
  endtask

  task automatic power_cycle(input int off, input int hold);
    int n, r1, k;
    bit held_ok;
    wait_running();
    step();
    #(off);
    pd_async = 1'b1;
    step();
    chk(out_oe === 1'b1 && pll_pd === 1'b0, "R2 no reaction at first edge", out_oe, 1);
    wait_oe(1'b0, n);
    chk(out_oe === 1'b0, "R5 stop reached", out_oe, 0);
    chk(pll_pd === 1'b1 && osc_pd === 1'b1, "R4 power-down controls", pll_pd, 1);
    chk(clk_p === 1'b0 && clk_n === 1'b1, "R8 parked pair", clk_p, 0);
    chk(($time - last_rise_t) >= CLK_PERIOD, "R5 clock stopped before release",
        int'($time - last_rise_t), CLK_PERIOD);
    held_ok = 1'b1;
    for (int i = 0; i < hold; i++) begin
      step();
      if (out_oe !== 1'b0 || pll_pd !== 1'b1 || osc_pd !== 1'b1) held_ok = 1'b0;
    end
    chk(held_ok, "R4 held while requested", held_ok, 1);
    #(off % 3);
    pd_async = 1'b0;
    wait_oe(1'b1, n);
    chk(n >= 2 && n <= 4, "R2 release latency", n, 3);
    chk(pll_pd === 1'b0 && osc_pd === 1'b0, "R6 power restored with enable", pll_pd, 0);
    r1 = rises;
    k = 0;
    while (rises == r1 && k < STAB + 6) begin
      step();
      k++;
    end
    chk(k >= STAB + 1 && k <= STAB + 2, "R6 settling window", k, STAB + 1);
    chk(runts == 0, "R3 no runt pulse", runts, 0);
    chk(diff_err == 0, "R8 complement", diff_err, 0);
  endtask

  task automatic abort_cycle(input int k);
    int n, r;
    wait_running();
    pd_async = 1'b1;
    wait_oe(1'b0, n);
    pd_async = 1'b0;
    wait_oe(1'b1, n);
    r = rises;
    for (int i = 0; i < k; i++) step();
    pd_async = 1'b1;
    wait_oe(1'b0, n);
    chk(out_oe === 1'b0 && n <= 4, "R7 abort latency", n, 3);
    chk(pll_pd === 1'b1, "R7 PLL off again", pll_pd, 1);
    chk(rises == r, "R7 no pulse in wait", rises - r, 0);
    step();
    pd_async = 1'b0;
  endtask

  task automatic short_pulse(input int off);
    int f, r;
    wait_running();
    f = oe_falls;
    step();
    #(off);
    pd_async = 1'b1;
    #(CLK_PERIOD);
    pd_async = 1'b0;
    for (int i = 0; i < 12; i++) step();
    r = rises;
    for (int i = 0; i < STAB + 10; i++) begin
      step();
      if (rises > r) break;
    end
    chk(oe_falls == f + 1, "R9 single full stop", oe_falls - f, 1);
    chk(rises > r, "R9 clock restarts", rises - r, 1);
    chk(runts == 0, "R3 no runt on short pulse", runts, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    n_chk = 0; n_fail = 0; rises = 0; runts = 0; diff_err = 0; oe_falls = 0;
    started = 1'b0; last_rise_t = 0; last_fall_t = 0;
    rst_n = 1'b0;
    pd_async = 1'b0;
    repeat (3) step();
    // R1 reset state
    chk(out_oe === 1'b1, "R1 enable in reset", out_oe, 1);
    chk(pll_pd === 1'b0 && osc_pd === 1'b0, "R1 powered in reset", pll_pd, 0);
    chk(clk_p === 1'b0 && clk_n === 1'b1, "R1 parked in reset", clk_p, 0);
    started = 1'b1;
    rst_n = 1'b1;
    n = 0;
    while (rises == 0 && n < STAB + 12) begin
      step();
      n++;
    end
    chk(n >= STAB && n <= STAB + 8, "R1 start after settling", n, STAB + 3);
    for (int off = 0; off <= 6; off++) begin
      power_cycle(off, 1);
      power_cycle(off, 5);
    end
    for (int k = 1; k <= STAB - 4; k++) abort_cycle(k);
    for (int off = 0; off <= 6; off += 2) short_pulse(off);
    wait_running();
    chk(runts == 0, "R3 final pulse widths", runts, 0);
    chk(diff_err == 0, "R8 final complement", diff_err, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule